// File: doc/BRIEF.md
# Segment Descriptor Cache Translator

This block holds one hidden cache entry per segment register and turns a segment-relative offset into a 24-bit linear address from that entry. Each entry stores a base, a limit and an access-rights byte. Every memory reference uses the cached values; the descriptor table is never read again during translation.

Segment loads arrive as requests carrying a register index, a 16-bit value, a mode flag and a far-jump flag. A real-mode load is applied in one cycle: the base becomes the value times 16. Only a far-jump load of the code register also rewrites the limit and rights; every other real-mode load keeps the limit and rights already in the entry. A protected-mode load treats the value as a selector. It fetches an 8-byte descriptor through a single-outstanding table-read port from either a global or a local table base, then checks it. On success it replaces the entry completely. On failure it leaves the entry unchanged and reports an error code.

Translation is a one-cycle registered stage. It either issues an address with a valid strobe or raises a fault when the offset exceeds the limit or the access type is not allowed.

Top module: `segcache_xlate`

## Requirements
- R1: After reset the block is idle (no busy, done, read request, valid or fault). Every entry has base 0, limit 0xFFFF and rights that mark it as a present, writable data segment, the code register included.
- R2: A real-mode load (`ld_prot`=0) sets the entry base to `ld_value`×16 and pulses `ld_done` with `ld_err`=0 in the cycle after the request.
- R3: A real-mode load of any register other than a far-jump load of the code register (index 0) leaves that entry's limit and rights unchanged.
- R4: A real-mode load of register 0 with `ld_far`=1 sets limit 0xFFFF and executable, readable code rights. Without `ld_far`, register 0 keeps its previous limit and rights.
- R5: A protected-mode load whose value has bits 1..0 non-zero completes with `ld_err`=1 (protection), issues no table read and leaves the entry unchanged.
- R6: A protected-mode load reads address (bit 2 of the value ? local base : global base) + (value with bits 2..0 cleared). `rd_req` stays high with a stable `rd_addr` until `rd_valid`.
- R7: Descriptor layout: limit in bits 15..0, base in bits 39..16, accessed in bit 40, type in bits 43..41, S in bit 44, privilege in bits 46..45, present in bit 47. Type bit 43 means executable and type bit 41 means writable for data. An accepted load replaces base, limit and rights together.
- R8: With S=0, with a non-executable descriptor for register 0, or with an executable descriptor for any other register, the load completes with `ld_err`=1 and the entry is unchanged.
- R9: A descriptor that passes R8 but has present=0 completes with `ld_err`=2 and the entry is unchanged.
- R10: An offset greater than the cached limit gives `lin_fault` and no `lin_valid`. An offset equal to the limit is accepted.
- R11: A write access to an executable segment, or to a data segment without the writable bit, gives `lin_fault` and no `lin_valid`.
- R12: An accepted access gives `lin_valid` one cycle after `ac_valid`, with `lin_addr` = base + offset modulo 2^24. There is exactly one result per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Write a table base register |
| tbl_wr_local | input | 1 | 1 selects the local table base, 0 the global one |
| tbl_wr_base | input | 24 | Table base value to write |
| ld_valid | input | 1 | Segment load request (ignored while busy) |
| ld_seg | input | 2 | Segment register index (0 = code) |
| ld_value | input | 16 | Segment value or selector |
| ld_prot | input | 1 | 1 = protected-mode load |
| ld_far | input | 1 | Real-mode code load comes from a far jump |
| ld_busy | output | 1 | Table read in progress |
| ld_done | output | 1 | One-cycle load completion pulse |
| ld_err | output | 2 | 0 ok, 1 protection, 2 not present |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 24 | Descriptor read address |
| rd_valid | input | 1 | Descriptor data valid |
| rd_data | input | 64 | Descriptor data |
| ac_valid | input | 1 | Access request |
| ac_seg | input | 2 | Segment register for the access |
| ac_ofs | input | 16 | Segment-relative offset |
| ac_write | input | 1 | 1 = write access |
| lin_valid | output | 1 | Linear address valid |
| lin_fault | output | 1 | Access rejected |
| lin_addr | output | 24 | Linear address |

## Verification
Translation is exercised with offsets at the reset default limit, exactly at and one past a loaded limit, and with a base near the top of the 24-bit space so the sum wraps. This separates an off-by-one limit compare from a missing carry wrap. Loads are mixed so that a protected-mode load is followed by a real-mode load of the same register. A leftover small, read-only limit must then still fault, which distinguishes a base-only real-mode update from a full one. Rejected loads (misaligned selector, system, wrong-kind and not-present descriptors) are each followed by an access that would reveal any partial update. Far and plain real-mode loads of the code register are compared to show which one resets the rights.

// File: rtl/segc_pkg.sv
package segc_pkg;

    localparam int BASE_W  = 24;
    localparam int LIMIT_W = 16;
    localparam int VAL_W   = 16;
    localparam int DESC_W  = 64;
    localparam int DUSED_W = 48;

    // Cache entry, ordered high to low as limit, rights byte, base.
    typedef struct packed {
        logic [LIMIT_W-1:0] limit;
        logic               present;
        logic [1:0]         dpl;
        logic               sflag;
        logic [2:0]         kind;     // [2] executable, [0] writable/readable
        logic               accessed;
        logic [BASE_W-1:0]  base;
    } seg_cache_t;

    typedef enum logic [1:0] {
        LD_OK   = 2'd0,
        LD_PROT = 2'd1,
        LD_NOTP = 2'd2
    } ld_err_e;

    typedef enum logic {
        LS_IDLE = 1'b0,
        LS_WAIT = 1'b1
    } ld_state_e;

    localparam logic [2:0] KIND_DATA_RW = 3'b001;
    localparam logic [2:0] KIND_CODE_RX = 3'b101;

    function automatic seg_cache_t reset_entry();
        seg_cache_t e;
        e.limit    = '1;
        e.present  = 1'b1;
        e.dpl      = 2'd0;
        e.sflag    = 1'b1;
        e.kind     = KIND_DATA_RW;
        e.accessed = 1'b1;
        e.base     = '0;
        return e;
    endfunction

    function automatic seg_cache_t real_code_entry(logic [BASE_W-1:0] b);
        seg_cache_t e;
        e      = reset_entry();
        e.kind = KIND_CODE_RX;
        e.base = b;
        return e;
    endfunction

    function automatic seg_cache_t decode_desc(logic [DUSED_W-1:0] d);
        seg_cache_t e;
        e.limit    = d[15:0];
        e.base     = d[39:16];
        e.accessed = d[40];
        e.kind     = d[43:41];
        e.sflag    = d[44];
        e.dpl      = d[46:45];
        e.present  = d[47];
        return e;
    endfunction

endpackage

// File: rtl/segc_cache_bank.sv
module segc_cache_bank
    import segc_pkg::*;
#(
    parameter int NUM_SEGS = 4,
    localparam int IDX_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic                        wr_full,
    input  seg_cache_t                  wr_ent,
    output seg_cache_t [NUM_SEGS-1:0]   entries
);

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
        seg_cache_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                if (wr_full) begin
                    ent_d = wr_ent;
                end else begin
                    ent_d.base = wr_ent.base;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= reset_entry();
            end else begin
                ent_q <= ent_d;
            end
        end

        assign entries[g] = ent_q;
    end

endmodule

// File: rtl/segc_loader.sv
module segc_loader
    import segc_pkg::*;
#(
    parameter int NUM_SEGS = 4,
    parameter int CS_INDEX = 0,
    localparam int IDX_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_valid,
    input  logic [IDX_W-1:0]    ld_seg,
    input  logic [VAL_W-1:0]    ld_value,
    input  logic                ld_prot,
    input  logic                ld_far,
    input  logic [BASE_W-1:0]   glb_base,
    input  logic [BASE_W-1:0]   loc_base,
    input  logic                rd_valid,
    input  logic [DESC_W-1:0]   rd_data,
    output logic                ld_busy,
    output logic                ld_done,
    output logic [1:0]          ld_err,
    output logic                rd_req,
    output logic [BASE_W-1:0]   rd_addr,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_idx,
    output logic                wr_full,
    output seg_cache_t          wr_ent
);

    typedef struct packed {
        ld_state_e          st;
        logic [IDX_W-1:0]   seg;
        logic [BASE_W-1:0]  addr;
        logic               done;
        ld_err_e            err;
    } ld_reg_t;

    ld_reg_t    ld_d, ld_q;
    seg_cache_t fetched;
    logic       tgt_is_code;
    logic       unused_desc_hi;

    assign unused_desc_hi = ^rd_data[DESC_W-1:DUSED_W];
    assign fetched        = decode_desc(rd_data[DUSED_W-1:0]);
    assign tgt_is_code    = (ld_q.seg == IDX_W'(CS_INDEX));

    always_comb begin
        ld_d      = ld_q;
        ld_d.done = 1'b0;
        wr_en     = 1'b0;
        wr_idx    = ld_q.seg;
        wr_full   = 1'b0;
        wr_ent    = fetched;
        unique case (ld_q.st)
            LS_IDLE: begin
                if (ld_valid) begin
                    if (!ld_prot) begin
                        // real mode: base update, rights only on far code load
                        wr_en  = 1'b1;
                        wr_idx = ld_seg;
                        if ((ld_seg == IDX_W'(CS_INDEX)) && ld_far) begin
                            wr_full = 1'b1;
                            wr_ent  = real_code_entry({4'h0, ld_value, 4'h0});
                        end else begin
                            wr_ent.base = {4'h0, ld_value, 4'h0};
                        end
                        ld_d.done = 1'b1;
                        ld_d.err  = LD_OK;
                    end else if (ld_value[1:0] != 2'b00) begin
                        ld_d.done = 1'b1;
                        ld_d.err  = LD_PROT;
                    end else begin
                        ld_d.st   = LS_WAIT;
                        ld_d.seg  = ld_seg;
                        ld_d.addr = (ld_value[2] ? loc_base : glb_base)
                                  + {8'h00, ld_value[15:3], 3'b000};
                    end
                end
            end
            LS_WAIT: begin
                if (rd_valid) begin
                    ld_d.st   = LS_IDLE;
                    ld_d.done = 1'b1;
                    if (!fetched.sflag) begin
                        ld_d.err = LD_PROT;
                    end else if (tgt_is_code != fetched.kind[2]) begin
                        ld_d.err = LD_PROT;
                    end else if (!fetched.present) begin
                        ld_d.err = LD_NOTP;
                    end else begin
                        ld_d.err = LD_OK;
                        wr_en    = 1'b1;
                        wr_full  = 1'b1;
                    end
                end
            end
            default: ld_d.st = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q <= '{st: LS_IDLE, seg: '0, addr: '0, done: 1'b0, err: LD_OK};
        end else begin
            ld_q <= ld_d;
        end
    end

    assign ld_busy = (ld_q.st == LS_WAIT);
    assign rd_req  = (ld_q.st == LS_WAIT);
    assign rd_addr = ld_q.addr;
    assign ld_done = ld_q.done;
    assign ld_err  = ld_q.err;

endmodule

// File: rtl/segc_xlate.sv
module segc_xlate
    import segc_pkg::*;
#(
    parameter int NUM_SEGS = 4,
    localparam int IDX_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ac_valid,
    input  logic [IDX_W-1:0]            ac_seg,
    input  logic [LIMIT_W-1:0]          ac_ofs,
    input  logic                        ac_write,
    input  seg_cache_t [NUM_SEGS-1:0]   entries,
    output logic                        lin_valid,
    output logic                        lin_fault,
    output logic [BASE_W-1:0]           lin_addr
);

    typedef struct packed {
        logic              valid;
        logic              fault;
        logic [BASE_W-1:0] addr;
    } xl_reg_t;

    xl_reg_t    xl_d, xl_q;
    seg_cache_t sel;
    logic       over_limit;
    logic       bad_write;
    logic       reject;

    always_comb begin
        sel        = entries[ac_seg];
        over_limit = (ac_ofs > sel.limit);
        bad_write  = ac_write && (sel.kind[2] || !sel.kind[0]);
        reject     = over_limit || bad_write || !sel.present;

        xl_d       = xl_q;
        xl_d.valid = ac_valid && !reject;
        xl_d.fault = ac_valid && reject;
        if (ac_valid && !reject) begin
            xl_d.addr = sel.base + {{(BASE_W-LIMIT_W){1'b0}}, ac_ofs};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xl_q <= '0;
        end else begin
            xl_q <= xl_d;
        end
    end

    assign lin_valid = xl_q.valid;
    assign lin_fault = xl_q.fault;
    assign lin_addr  = xl_q.addr;

endmodule

// File: rtl/segcache_xlate.sv
module segcache_xlate
    import segc_pkg::*;
#(
    parameter int NUM_SEGS = 4,
    parameter int CS_INDEX = 0,
    localparam int IDX_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tbl_wr_en,
    input  logic                tbl_wr_local,
    input  logic [BASE_W-1:0]   tbl_wr_base,
    input  logic                ld_valid,
    input  logic [IDX_W-1:0]    ld_seg,
    input  logic [VAL_W-1:0]    ld_value,
    input  logic                ld_prot,
    input  logic                ld_far,
    output logic                ld_busy,
    output logic                ld_done,
    output logic [1:0]          ld_err,
    output logic                rd_req,
    output logic [BASE_W-1:0]   rd_addr,
    input  logic                rd_valid,
    input  logic [DESC_W-1:0]   rd_data,
    input  logic                ac_valid,
    input  logic [IDX_W-1:0]    ac_seg,
    input  logic [LIMIT_W-1:0]  ac_ofs,
    input  logic                ac_write,
    output logic                lin_valid,
    output logic                lin_fault,
    output logic [BASE_W-1:0]   lin_addr
);

    typedef struct packed {
        logic [BASE_W-1:0] glb;
        logic [BASE_W-1:0] loc;
    } tbl_reg_t;

    tbl_reg_t                  tbl_d, tbl_q;
    seg_cache_t [NUM_SEGS-1:0] entries;
    logic                      wr_en;
    logic [IDX_W-1:0]          wr_idx;
    logic                      wr_full;
    seg_cache_t                wr_ent;

    always_comb begin
        tbl_d = tbl_q;
        if (tbl_wr_en) begin
            if (tbl_wr_local) begin
                tbl_d.loc = tbl_wr_base;
            end else begin
                tbl_d.glb = tbl_wr_base;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    segc_loader #(.NUM_SEGS(NUM_SEGS), .CS_INDEX(CS_INDEX)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_seg   (ld_seg),
        .ld_value (ld_value),
        .ld_prot  (ld_prot),
        .ld_far   (ld_far),
        .glb_base (tbl_q.glb),
        .loc_base (tbl_q.loc),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .ld_busy  (ld_busy),
        .ld_done  (ld_done),
        .ld_err   (ld_err),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_full  (wr_full),
        .wr_ent   (wr_ent)
    );

    segc_cache_bank #(.NUM_SEGS(NUM_SEGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_full (wr_full),
        .wr_ent  (wr_ent),
        .entries (entries)
    );

    segc_xlate #(.NUM_SEGS(NUM_SEGS)) u_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ac_valid  (ac_valid),
        .ac_seg    (ac_seg),
        .ac_ofs    (ac_ofs),
        .ac_write  (ac_write),
        .entries   (entries),
        .lin_valid (lin_valid),
        .lin_fault (lin_fault),
        .lin_addr  (lin_addr)
    );

endmodule

// File: rtl/segc_checker.sv
module segc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ld_valid,
    input logic        ld_busy,
    input logic        ld_prot,
    input logic [15:0] ld_value,
    input logic        ld_done,
    input logic [1:0]  ld_err,
    input logic        rd_req,
    input logic        rd_valid,
    input logic [23:0] rd_addr,
    input logic        ac_valid,
    input logic        lin_valid,
    input logic        lin_fault
);

    AST_REAL_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_busy && !ld_prot) |=> (ld_done && ld_err == 2'd0)); // R2

    AST_DONE_LEAVES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> !ld_busy); // R2

    AST_MISALIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_busy && ld_prot && ld_value[1:0] != 2'b00)
        |=> (ld_done && ld_err == 2'd1 && !rd_req)); // R5

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R6

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lin_valid, lin_fault})); // R10

    AST_RESULT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_valid || lin_fault) |-> $past(ac_valid)); // R12

endmodule

bind segcache_xlate segc_checker u_segc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_busy   (ld_busy),
    .ld_prot   (ld_prot),
    .ld_value  (ld_value),
    .ld_done   (ld_done),
    .ld_err    (ld_err),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .ac_valid  (ac_valid),
    .lin_valid (lin_valid),
    .lin_fault (lin_fault)
);

// File: tb/tb_segcache_xlate.sv
module tb_segcache_xlate;

    localparam int IDXW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        tbl_wr_en, tbl_wr_local;
    logic [23:0] tbl_wr_base;
    logic        ld_valid, ld_prot, ld_far;
    logic [IDXW-1:0] ld_seg, ac_seg;
    logic [15:0] ld_value, ac_ofs;
    logic        ld_busy, ld_done;
    logic [1:0]  ld_err;
    logic        rd_req, rd_valid;
    logic [23:0] rd_addr, lin_addr;
    logic [63:0] rd_data;
    logic        ac_valid, ac_write, lin_valid, lin_fault;

    segcache_xlate dut (.*);

    int checks = 0;
    int fails  = 0;
    int reads  = 0;
    logic [23:0] last_rd = '0;
    bit finished = 0;
    logic [63:0] tmem [64];

    typedef struct packed {
        logic        fault;
        logic [23:0] addr;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    task automatic chk(bit ok, string tag, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [63:0] mkdesc(logic [23:0] b, logic [15:0] l, logic [7:0] acc);
        return {16'h0000, acc, b, l};
    endfunction

    // monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        exp_t  e;
        string t;
        if (rst_n && (lin_valid || lin_fault)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12", "unexpected result", {lin_fault, lin_addr}, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(lin_fault == e.fault && lin_valid == !e.fault, t, "fault", lin_fault, e.fault);
                if (!e.fault) chk(lin_addr == e.addr, t, "addr", lin_addr, e.addr);
            end
        end
    end

    // descriptor table responder, two cycles of latency
    initial begin
        rd_valid = 1'b0;
        rd_data  = '0;
        forever begin
            @(negedge clk);
            if (rst_n && rd_req) begin
                reads++;
                last_rd = rd_addr;
                repeat (2) @(posedge clk);
                #1;
                rd_valid = 1'b1;
                rd_data  = tmem[rd_addr[8:3]];
                @(posedge clk);
                #1;
                rd_valid = 1'b0;
            end
        end
    end

    task automatic access(int seg, logic [15:0] ofs, bit wr, bit ef, logic [23:0] ea, string tag);
        exp_q.push_back('{fault: ef, addr: ea});
        tag_q.push_back(tag);
        @(posedge clk); #1;
        ac_valid = 1'b1; ac_seg = IDXW'(seg); ac_ofs = ofs; ac_write = wr;
        @(posedge clk); #1;
        ac_valid = 1'b0; ac_write = 1'b0;
    endtask

    task automatic load(int seg, logic [15:0] val, bit prot, bit far, logic [1:0] eerr, string tag);
        bit seen = 0;
        @(posedge clk); #1;
        ld_valid = 1'b1; ld_seg = IDXW'(seg); ld_value = val; ld_prot = prot; ld_far = far;
        @(posedge clk); #1;
        ld_valid = 1'b0; ld_far = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (ld_done) begin seen = 1; break; end
            @(posedge clk); #1;
        end
        chk(seen && ld_err == eerr, tag, "load result", {seen, ld_err}, {1'b1, eerr});
    endtask

    task automatic set_table(bit loc, logic [23:0] b);
        @(posedge clk); #1;
        tbl_wr_en = 1'b1; tbl_wr_local = loc; tbl_wr_base = b;
        @(posedge clk); #1;
        tbl_wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int rd_before;
        for (int i = 0; i < 64; i++) tmem[i] = '0;
        tmem[9]  = mkdesc(24'h200000, 16'h00FF, 8'h90); // read-only data
        tmem[10] = mkdesc(24'h300000, 16'h0FFF, 8'h9A); // code
        tmem[11] = mkdesc(24'h400000, 16'hFFFF, 8'h82); // system
        tmem[12] = mkdesc(24'h500000, 16'hFFFF, 8'h12); // not present data
        tmem[33] = mkdesc(24'hFFFF00, 16'hFFFF, 8'h92); // writable data, local

        rst_n = 1'b0;
        tbl_wr_en = 0; tbl_wr_local = 0; tbl_wr_base = '0;
        ld_valid = 0; ld_seg = '0; ld_value = '0; ld_prot = 0; ld_far = 0;
        ac_valid = 0; ac_seg = '0; ac_ofs = '0; ac_write = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!ld_busy && !ld_done && !rd_req && !lin_valid && !lin_fault, "R1", "idle outputs",
            {ld_busy, ld_done, rd_req, lin_valid, lin_fault}, 0);

        // R1: reset entries are writable data, base 0, limit FFFF
        access(0, 16'h1234, 1, 0, 24'h001234, "R1");
        access(3, 16'hFFFF, 0, 0, 24'h00FFFF, "R1");

        // R2: real-mode base
        load(1, 16'h1234, 0, 0, 2'd0, "R2");
        access(1, 16'h0010, 0, 0, 24'h012350, "R2");
        load(2, 16'hFFFF, 0, 0, 2'd0, "R2");
        access(2, 16'hFFFF, 0, 0, 24'h10FFEF, "R2");

        set_table(0, 24'h000040);
        set_table(1, 24'h000100);

        // R5: misaligned selector, no read, entry unchanged
        rd_before = reads;
        load(1, 16'h0009, 1, 0, 2'd1, "R5");
        chk(reads == rd_before, "R5", "table reads", reads, rd_before);
        access(1, 16'h0010, 0, 0, 24'h012350, "R5");

        // R6/R7/R10/R11: global read-only data, limit FF
        load(1, 16'h0008, 1, 0, 2'd0, "R7");
        chk(last_rd == 24'h000048, "R6", "global read addr", last_rd, 24'h48);
        access(1, 16'h00FF, 0, 0, 24'h2000FF, "R10");
        access(1, 16'h0100, 0, 1, 24'h0, "R10");
        access(1, 16'h0000, 1, 1, 24'h0, "R11");

        // R6/R12: local table, base wraps
        load(2, 16'h000C, 1, 0, 2'd0, "R6");
        chk(last_rd == 24'h000108, "R6", "local read addr", last_rd, 24'h108);
        access(2, 16'h0200, 1, 0, 24'h000100, "R12");

        // R3: real load keeps small limit and read-only rights
        load(1, 16'h0100, 0, 0, 2'd0, "R3");
        access(1, 16'h0010, 0, 0, 24'h001010, "R3");
        access(1, 16'h0100, 0, 1, 24'h0, "R3");
        access(1, 16'h0000, 1, 1, 24'h0, "R3");

        // R8: type errors leave entries alone
        load(1, 16'h0010, 1, 0, 2'd1, "R8");
        access(1, 16'h0010, 0, 0, 24'h001010, "R8");
        load(3, 16'h0018, 1, 0, 2'd1, "R8");
        load(0, 16'h0008, 1, 0, 2'd1, "R8");
        access(0, 16'h0020, 1, 0, 24'h000020, "R8");
        load(0, 16'h0010, 1, 0, 2'd0, "R8");
        access(0, 16'h0FFF, 0, 0, 24'h300FFF, "R10");
        access(0, 16'h0000, 1, 1, 24'h0, "R11");
        access(0, 16'h1000, 0, 1, 24'h0, "R10");

        // R9: not present
        load(3, 16'h0020, 1, 0, 2'd2, "R9");
        access(3, 16'h0020, 1, 0, 24'h000020, "R9");

        // R4: plain vs far real-mode code load
        load(0, 16'h2000, 0, 0, 2'd0, "R4");
        access(0, 16'h1000, 0, 1, 24'h0, "R4");
        access(0, 16'h0010, 0, 0, 24'h020010, "R4");
        load(0, 16'h3000, 0, 1, 2'd0, "R4");
        access(0, 16'hFFFF, 0, 0, 24'h03FFFF, "R4");
        access(0, 16'h0000, 1, 1, 24'h0, "R4");

        repeat (4) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R12", "results pending", exp_q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule